// File: doc/BRIEF.md
# Hysteretic Spread-Spectrum Boost Switch Gate

This block generates the switch-drive pulse train for a discontinuous-mode boost converter that is regulated in bursts. An external comparator flags when the converter output has sagged below a programmable reference. While that flag is set the block issues switching pulses. Once the flag clears, the block finishes the pulse in progress and then parks the drive low. A 4-bit code register, written from a simple strobe port, drives the external reference DAC that sets the threshold.

The pulses come from a phase-accumulator oscillator. Its increment is swept as a symmetric triangle, so the switching energy is spread across a band instead of sitting on one tone. With the default 32 MHz system clock and a 16-bit accumulator, the increment runs from 1638 to 6554, which is about 0.8 MHz to 3.2 MHz. It moves in equal steps of 1229, and each step is held for a fixed 64 system cycles. Because every level is held for the same time, the time-averaged increment is exactly 4096, which gives a mean of 2 MHz.

Top module: `burst_boost_gate`

## Requirements
- R1: After reset, `sw_drv`, `running` and `ref_code` are all 0, and the sweep starts at its midpoint increment (4096).
- R2: A cycle with `ref_we`=1 loads `ref_din` into `ref_code`, visible after the next rising edge. When `ref_we`=0, `ref_code` holds its value whatever `ref_din` carries.
- R3: `cmp_low` passes through a two-flop synchronizer. While idle, a 1 on `cmp_low` raises `running` on the third rising edge after it is applied, and not before.
- R4: Each burst starts from zero phase, so `sw_drv` is low when `running` rises. `sw_drv` never rises while `running` is 0.
- R5: While running, the interval from one rising edge of `sw_drv` to the next is between 9 and 41 system cycles. Every high phase lasts at least 4 cycles.
- R6: The sweep reaches both limits. Over a run, the shortest rise-to-rise interval is at most 11 cycles and the longest is at least 36 cycles.
- R7: While running continuously, 2048 consecutive cycles contain 128 ± 2 rising edges of `sw_drv`, which is a mean of 1/16 of the system clock.
- R8: When the synchronized comparator reads 0, switching stops only at the end of an accumulator period. `running` falls on the same edge as `sw_drv` falls, so the last pulse is never cut short.
- R9: While `cmp_low` stays 0 and the block is idle, `sw_drv` and `running` stay 0.
- R10: The sweep increment stays within [1638, 6554]. Each step changes it by no more than 1229, it reverses direction at each limit, and it changes only once every 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (32 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cmp_low | input | 1 | Asynchronous comparator flag: 1 means the output is below the reference |
| ref_we | input | 1 | Write strobe for the reference code |
| ref_din | input | 4 | Reference code to write |
| ref_code | output | 4 | Registered reference code to the external DAC |
| sw_drv | output | 1 | Switch-drive pulse (accumulator MSB) |
| running | output | 1 | High while switching pulses are being issued |

## Verification
The bound checker checks a set of rules on every cycle:
- the drive stays quiet while idle;
- a burst starts only on a synchronized request;
- stopping coincides with a falling edge of the drive;
- the sweep increment stays in range and moves by bounded steps at the fixed cadence;
- the reference register loads correctly.

Some behaviours can only be shown by the bench's directed scenarios, because they depend on how the drive behaves across many periods:
- the three-edge start latency;
- the spread of periods between the two frequency limits;
- the 2 MHz mean taken over whole sweep cycles;
- the quiet interval after a stop.

// File: rtl/boost_gate_pkg.sv
package boost_gate_pkg;
  typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DOWN = 1'b1} sweep_dir_e;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bg_sweep.sv
module bg_sweep
  import boost_gate_pkg::*;
#(
  parameter int INC_W   = 16,
  parameter int INC_MIN = 1638,
  parameter int INC_MAX = 6554,
  parameter int INC_RST = 4096,
  parameter int STEP    = 1229,
  parameter int HOLD    = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [INC_W-1:0] inc
);
  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [INC_W-1:0] LO      = INC_W'(INC_MIN);
  localparam logic [INC_W-1:0] HI      = INC_W'(INC_MAX);
  localparam logic [INC_W-1:0] STP     = INC_W'(STEP);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HOLD - 1);

  logic [CNT_W-1:0] cnt_q;
  sweep_dir_e       dir_q;
  logic [INC_W-1:0] inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= SWEEP_UP;
      inc_q <= INC_W'(INC_RST);
    end else if (cnt_q == CNT_END) begin
      cnt_q <= '0;
      if (dir_q == SWEEP_UP) begin
        if (inc_q >= HI - STP) begin
          inc_q <= HI;
          dir_q <= SWEEP_DOWN;
        end else begin
          inc_q <= inc_q + STP;
        end
      end else begin
        if (inc_q <= LO + STP) begin
          inc_q <= LO;
          dir_q <= SWEEP_UP;
        end else begin
          inc_q <= inc_q - STP;
        end
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign inc = inc_q;
endmodule

// File: rtl/bg_phase.sv
module bg_phase #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clear,
  input  logic [ACC_W-1:0] inc,
  output logic             msb,
  output logic             wrap
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, inc};
  assign wrap = en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (en)      acc_q <= sum[ACC_W-1:0];
  end

  assign msb = acc_q[ACC_W-1];
endmodule

// File: rtl/burst_boost_gate.sv
module burst_boost_gate #(
  parameter int ACC_W       = 16,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int INC_MIN     = 1638,
  parameter int INC_MAX     = 6554,
  parameter int INC_MID     = 4096,
  parameter int STEP        = 1229,
  parameter int HOLD        = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_low,
  input  logic              ref_we,
  input  logic [CODE_W-1:0] ref_din,
  output logic [CODE_W-1:0] ref_code,
  output logic              sw_drv,
  output logic              running
);
  logic              cmp_sync;
  logic [ACC_W-1:0]  inc_q;
  logic              wrap;
  logic              run_q;
  logic              start_req;
  logic              stop_req;
  logic [CODE_W-1:0] code_q;

  bg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_low), .q(cmp_sync)
  );

  bg_sweep #(
    .INC_W(ACC_W), .INC_MIN(INC_MIN), .INC_MAX(INC_MAX),
    .INC_RST(INC_MID), .STEP(STEP), .HOLD(HOLD)
  ) u_sweep (
    .clk(clk), .rst(rst), .inc(inc_q)
  );

  assign start_req = !run_q && cmp_sync;
  assign stop_req  = run_q && wrap && !cmp_sync;

  bg_phase #(.ACC_W(ACC_W)) u_phase (
    .clk(clk), .rst(rst), .en(run_q), .clear(stop_req),
    .inc(inc_q), .msb(sw_drv), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)            run_q <= 1'b0;
    else if (start_req) run_q <= 1'b1;
    else if (stop_req)  run_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         code_q <= '0;
    else if (ref_we) code_q <= ref_din;
  end

  assign running  = run_q;
  assign ref_code = code_q;
endmodule

// File: rtl/burst_boost_gate_chk.sv
module burst_boost_gate_chk #(
  parameter int ACC_W   = 16,
  parameter int CODE_W  = 4,
  parameter int INC_MIN = 1638,
  parameter int INC_MAX = 6554,
  parameter int STEP    = 1229,
  parameter int HOLD    = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_sync,
  input logic [ACC_W-1:0]  inc_q,
  input logic              ref_we,
  input logic [CODE_W-1:0] ref_din,
  input logic [CODE_W-1:0] ref_code,
  input logic              sw_drv,
  input logic              running
);
  int unsigned hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   hold_cnt <= 0;
    else if (!$stable(inc_q))  hold_cnt <= 1;
    else                       hold_cnt <= hold_cnt + 1;
  end

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !running |-> !sw_drv);

  a_r4_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_drv) |-> running);

  a_r3_start_on_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ($past(cmp_sync) && !sw_drv));

  a_r8_stop_at_period_end: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> (!sw_drv && $past(sw_drv) && !$past(cmp_sync)));

  a_r10_inc_range: assert property (@(posedge clk) disable iff (rst)
    (int'(inc_q) >= INC_MIN) && (int'(inc_q) <= INC_MAX));

  a_r10_inc_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(inc_q) |->
      ((int'(inc_q) - int'($past(inc_q)) <= STEP) &&
       (int'($past(inc_q)) - int'(inc_q) <= STEP)));

  a_r10_inc_cadence: assert property (@(posedge clk) disable iff (rst)
    !$stable(inc_q) |-> (hold_cnt == HOLD));

  a_r2_ref_load: assert property (@(posedge clk) disable iff (rst)
    $past(ref_we) |-> (ref_code == $past(ref_din)));
endmodule

bind burst_boost_gate burst_boost_gate_chk #(
  .ACC_W(ACC_W), .CODE_W(CODE_W), .INC_MIN(INC_MIN),
  .INC_MAX(INC_MAX), .STEP(STEP), .HOLD(HOLD)
) u_chk (
  .clk(clk), .rst(rst), .cmp_sync(cmp_sync), .inc_q(inc_q),
  .ref_we(ref_we), .ref_din(ref_din), .ref_code(ref_code),
  .sw_drv(sw_drv), .running(running)
);

// File: tb/burst_boost_gate_bench.sv
module burst_boost_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_low = 1'b0;
  logic       ref_we = 1'b0;
  logic [3:0] ref_din = 4'h0;
  logic [3:0] ref_code;
  logic       sw_drv;
  logic       running;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  burst_boost_gate u_burst_boost_gate (
    .clk(clk), .rst(rst), .cmp_low(cmp_low), .ref_we(ref_we),
    .ref_din(ref_din), .ref_code(ref_code), .sw_drv(sw_drv), .running(running)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sw_drv == 1'b0,   "R1 sw_drv after reset",   int'(sw_drv), 0);
    check(running == 1'b0,  "R1 running after reset",  int'(running), 0);
    check(ref_code == 4'h0, "R1 ref_code after reset", int'(ref_code), 0);
  endtask

  task automatic t_ref_write();
    ref_we = 1'b1; ref_din = 4'hA;
    @(negedge clk);
    ref_we = 1'b0;
    check(ref_code == 4'hA, "R2 load code", int'(ref_code), 10);
    ref_din = 4'h5;
    repeat (2) @(negedge clk);
    check(ref_code == 4'hA, "R2 hold without strobe", int'(ref_code), 10);
    ref_we = 1'b1; ref_din = 4'hF;
    @(negedge clk);
    ref_we = 1'b0;
    check(ref_code == 4'hF, "R2 load max code", int'(ref_code), 15);
  endtask

  task automatic t_idle(input int cycles);
    int highs = 0;
    int runs  = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sw_drv)  highs++;
      if (running) runs++;
    end
    check(highs == 0, "R9 no pulses while idle", highs, 0);
    check(runs == 0,  "R9 running low while idle", runs, 0);
  endtask

  task automatic t_start();
    cmp_low = 1'b1;
    repeat (2) @(negedge clk);
    check(running == 1'b0, "R3 not running after two edges", int'(running), 0);
    @(negedge clk);
    check(running == 1'b1, "R3 running after third edge", int'(running), 1);
    check(sw_drv == 1'b0,  "R4 burst starts low", int'(sw_drv), 0);
  endtask

  task automatic t_spread();
    int  prev     = 0;
    int  last_r   = -1;
    int  hi_len   = 0;
    int  pmin     = 1000;
    int  pmax     = 0;
    int  bad_per  = 0;
    int  bad_hi   = 0;
    int  rises    = 0;
    int  bad_val  = 0;
    int  bad_hval = 0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (sw_drv && !prev) begin
        rises++;
        if (last_r >= 0) begin
          if (i - last_r < pmin) pmin = i - last_r;
          if (i - last_r > pmax) pmax = i - last_r;
          if ((i - last_r < 9) || (i - last_r > 41)) begin
            bad_per++;
            bad_val = i - last_r;
          end
        end
        last_r = i;
      end
      if (sw_drv) hi_len++;
      if (!sw_drv && prev) begin
        if (hi_len < 4) begin
          bad_hi++;
          bad_hval = hi_len;
        end
        hi_len = 0;
      end
      prev = int'(sw_drv);
    end
    check(bad_per == 0, "R5 period within 9..41 cycles", bad_val, 16);
    check(bad_hi == 0,  "R5 high phase at least 4 cycles", bad_hval, 4);
    check(pmin <= 11,   "R6 short period reached", pmin, 11);
    check(pmax >= 36,   "R6 long period reached", pmax, 36);
    check((rises >= 126) && (rises <= 130), "R7 mean rate 1/16", rises, 128);
  endtask

  task automatic t_stop();
    int prev  = int'(sw_drv);
    int found = 0;
    int drv_at_fall  = 0;
    int prev_at_fall = 0;
    cmp_low = 1'b0;
    for (int i = 0; i < 60 && found == 0; i++) begin
      @(negedge clk);
      if (!running) begin
        found        = 1;
        drv_at_fall  = int'(sw_drv);
        prev_at_fall = prev;
      end
      prev = int'(sw_drv);
    end
    check(found == 1, "R8 stop occurs", found, 1);
    check((drv_at_fall == 0) && (prev_at_fall == 1),
          "R8 stop aligned with falling drive", prev_at_fall, 1);
  endtask

  initial begin
    t_reset();
    t_ref_write();
    t_idle(200);
    t_start();
    t_spread();
    t_stop();
    t_idle(300);
    t_start();
    repeat (37) @(negedge clk);
    t_stop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule